// File: doc/BRIEF.md
# Channel Request Issuer with Backpressure Rate Halving

The block sits on the client side of a ready-gated channel request interface. It holds a small programmable calendar of slots, each slot naming a channel ID and a six-bit supplemental idle count (SIC) adjustment. It walks the calendar in circular order and presents one request per issue slot, with `valid_o` marking the cycles that carry a request. The calendar pointer moves only on cycles that issue.

After reset nothing is issued until `rdy_i` has been seen high at a clock edge. From then on, a high `rdy_i` allows a request on every enabled cycle. A low `rdy_i` does not stop the issuer. It drops the issue rate to every other cycle, and the first low cycle never issues. When `rdy_i` returns high, full rate resumes in that same cycle. The `enable_i` input starts and stops issuing without losing the calendar position.

Software loads the calendar through a one-entry-per-cycle write port and picks how many slots are active with `cal_len_i`.

Top module: `chan_req_pacer`

## Requirements
- R1: During reset `valid_o` is low and the pointer is at slot 0. Out of reset, slot k holds channel ID k and SIC 0.
- R2: `valid_o` stays low until `rdy_i` has been sampled high at a rising clock edge after reset. The earliest request is in the cycle after that edge.
- R3: When the block is armed, `rdy_i` is high and `enable_i` is high, `valid_o` is high in every cycle.
- R4: While `rdy_i` is low, `valid_o` is never high in two consecutive cycles. In a run of low cycles with the block armed and enabled, the first low cycle does not issue, and issues then fall on alternate cycles (0,1,0,1,...).
- R5: In the first cycle that `rdy_i` is high again, the block returns to one request per cycle.
- R6: `ch_o` and `sic_o` always show the contents of the slot under the pointer. Each issued request moves the pointer by one. After the request from slot L-1, where L is the effective length, the pointer returns to 0. A pointer at or above L-1 also returns to 0 on its next issue.
- R7: The effective calendar length is `cal_len_i`, except that 0, or any value above NUM_SLOTS, selects NUM_SLOTS.
- R8: While `enable_i` is low, `valid_o` is low and the pointer holds. Issuing resumes from the same slot.
- R9: A calendar write to a slot changes that slot's `ch_o` and `sic_o` from the following cycle on. A SIC of 0 is carried unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Issue enable |
| rdy_i | input | 1 | Downstream ready; low requests a halved rate |
| cal_len_i | input | LEN_W | Number of active calendar slots |
| wr_en_i | input | 1 | Calendar write strobe |
| wr_addr_i | input | PTR_W | Calendar slot to write |
| wr_ch_i | input | CH_W | Channel ID to write |
| wr_sic_i | input | 6 | SIC value to write |
| valid_o | output | 1 | Request valid this cycle |
| ch_o | output | CH_W | Channel ID of the current slot |
| sic_o | output | 6 | SIC adjustment of the current slot |

## Verification
The bench builds the block with six slots and a five-bit channel ID. With six slots the pointer and length widths are equal and the slot count is not a power of two, so a length value of 7 falls above the slot count and exercises the clamp, and the wrap at slot 5 is not a natural binary rollover. The short calendar lets tests cover wraps at lengths 1, 3 and 6, a pointer that already sits beyond a newly shortened length, and the full alternate-cycle pattern of halved mode, all within a few dozen cycles.

// File: rtl/chan_req_pkg.sv
package chan_req_pkg;
  localparam int unsigned SIC_W = 6;
  typedef logic [SIC_W-1:0] sic_t;
  typedef enum logic {PACE_FULL = 1'b0, PACE_HALF = 1'b1} pace_e;
endpackage

// File: rtl/cal_table.sv
module cal_table
  import chan_req_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned CH_W      = 7,
  parameter int unsigned PTR_W     = $clog2(NUM_SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_addr_i,
  input  logic [CH_W-1:0]  wr_ch_i,
  input  sic_t             wr_sic_i,
  input  logic [PTR_W-1:0] rd_addr_i,
  output logic [CH_W-1:0]  rd_ch_o,
  output sic_t             rd_sic_o
);
  logic [CH_W-1:0] ch_q  [NUM_SLOTS];
  sic_t            sic_q [NUM_SLOTS];

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == PTR_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ch_q[k]  <= CH_W'(k);
        sic_q[k] <= '0;
      end else if (hit) begin
        ch_q[k]  <= wr_ch_i;
        sic_q[k] <= wr_sic_i;
      end
    end
  end

  always_comb begin
    rd_ch_o  = ch_q[0];
    rd_sic_o = sic_q[0];
    for (int k = 1; k < NUM_SLOTS; k++) begin
      if (rd_addr_i == PTR_W'(k)) begin
        rd_ch_o  = ch_q[k];
        rd_sic_o = sic_q[k];
      end
    end
  end
endmodule

// File: rtl/issue_pacer.sv
module issue_pacer
  import chan_req_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_i,
  input  logic enable_i,
  output logic issue_o
);
  logic  armed_q;
  logic  phase_q;
  pace_e mode;

  assign mode = rdy_i ? PACE_FULL : PACE_HALF;

  // phase clears while ready is high so the first low cycle is always empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      if (rdy_i) armed_q <= 1'b1;
      phase_q <= (mode == PACE_HALF) ? ~phase_q : 1'b0;
    end
  end

  always_comb begin
    unique case (mode)
      PACE_FULL: issue_o = enable_i && armed_q;
      PACE_HALF: issue_o = enable_i && armed_q && phase_q;
      default:   issue_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cal_ptr.sv
module cal_ptr #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned PTR_W     = $clog2(NUM_SLOTS),
  parameter int unsigned LEN_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [LEN_W-1:0] FullLen = LEN_W'(NUM_SLOTS);

  logic [LEN_W-1:0] eff_len;
  logic             at_last;
  logic [PTR_W-1:0] ptr_q;

  assign eff_len = ((len_i == '0) || (len_i > FullLen)) ? FullLen : len_i;
  assign at_last = LEN_W'(ptr_q) >= (eff_len - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (adv_i)   ptr_q <= at_last ? '0 : ptr_q + PTR_W'(1);
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/chan_req_pacer.sv
module chan_req_pacer
  import chan_req_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned CH_W      = 7,
  localparam int unsigned PTR_W    = $clog2(NUM_SLOTS),
  localparam int unsigned LEN_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             rdy_i,
  input  logic [LEN_W-1:0] cal_len_i,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_addr_i,
  input  logic [CH_W-1:0]  wr_ch_i,
  input  logic [5:0]       wr_sic_i,
  output logic             valid_o,
  output logic [CH_W-1:0]  ch_o,
  output logic [5:0]       sic_o
);
  logic             issue;
  logic [PTR_W-1:0] slot_ptr;

  issue_pacer u_pacer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rdy_i   (rdy_i),
    .enable_i(enable_i),
    .issue_o (issue)
  );

  cal_ptr #(
    .NUM_SLOTS(NUM_SLOTS),
    .PTR_W    (PTR_W),
    .LEN_W    (LEN_W)
  ) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (issue),
    .len_i (cal_len_i),
    .ptr_o (slot_ptr)
  );

  cal_table #(
    .NUM_SLOTS(NUM_SLOTS),
    .CH_W     (CH_W),
    .PTR_W    (PTR_W)
  ) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_ch_i  (wr_ch_i),
    .wr_sic_i (wr_sic_i),
    .rd_addr_i(slot_ptr),
    .rd_ch_o  (ch_o),
    .rd_sic_o (sic_o)
  );

  assign valid_o = issue;
endmodule

// File: rtl/chan_req_pacer_chk.sv
module chan_req_pacer_chk #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned PTR_W     = $clog2(NUM_SLOTS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rdy_i,
  input logic             enable_i,
  input logic             valid_o,
  input logic [PTR_W-1:0] slot_ptr
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seen_q <= 1'b0;
    else if (rdy_i) seen_q <= 1'b1;
  end

  // R2
  no_early_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> seen_q);

  // R3
  full_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && rdy_i && enable_i) |-> valid_o);

  // R4
  no_burst_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !rdy_i) |-> !$past(valid_o));

  // R4
  low_rate_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !rdy_i && $past(!rdy_i) && enable_i && $past(enable_i) && !$past(valid_o))
      |-> valid_o);

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !valid_o);

  // R8
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |=> $stable(slot_ptr));

  // R6
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_ptr < PTR_W'(NUM_SLOTS));
endmodule

bind chan_req_pacer chan_req_pacer_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .PTR_W    (PTR_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rdy_i   (rdy_i),
  .enable_i(enable_i),
  .valid_o (valid_o),
  .slot_ptr(slot_ptr)
);

// File: tb/chan_req_pacer_bench.sv
module chan_req_pacer_bench;
  localparam int NS = 6;
  localparam int CW = 5;
  localparam int PW = $clog2(NS);
  localparam int LW = $clog2(NS + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          enable_i = 1'b0;
  logic          rdy_i = 1'b0;
  logic [LW-1:0] cal_len_i = '0;
  logic          wr_en_i = 1'b0;
  logic [PW-1:0] wr_addr_i = '0;
  logic [CW-1:0] wr_ch_i = '0;
  logic [5:0]    wr_sic_i = '0;
  logic          valid_o;
  logic [CW-1:0] ch_o;
  logic [5:0]    sic_o;

  always #2 clk_i = ~clk_i;

  chan_req_pacer #(.NUM_SLOTS(NS), .CH_W(CW)) u_chan_req_pacer (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [CW-1:0] m_ch  [NS];
  logic [5:0]    m_sic [NS];
  int m_ptr = 0;

  function automatic int eff_len();
    int l = int'(cal_len_i);
    return (l == 0 || l > NS) ? NS : l;
  endfunction

  // check one cycle mid-period, then update the model and step past the next edge
  task automatic tick(input logic ev, input string rq);
    @(negedge clk_i);
    checks++;
    if (valid_o !== ev || ch_o !== m_ch[m_ptr] || sic_o !== m_sic[m_ptr]) begin
      fails++;
      $display("FAIL %s: valid/ch/sic = %0b/%0d/%0d, expected %0b/%0d/%0d",
               rq, valid_o, ch_o, sic_o, ev, m_ch[m_ptr], m_sic[m_ptr]);
    end
    if (ev) m_ptr = (m_ptr >= eff_len() - 1) ? 0 : m_ptr + 1;
    if (wr_en_i) begin
      m_ch[int'(wr_addr_i)]  = wr_ch_i;
      m_sic[int'(wr_addr_i)] = wr_sic_i;
    end
    @(posedge clk_i);
    #1;
  endtask

  task automatic t_reset;
    for (int k = 0; k < NS; k++) begin
      m_ch[k]  = CW'(k);
      m_sic[k] = '0;
    end
    tick(1'b0, "R1");
    tick(1'b0, "R1");
    rst_ni = 1'b1;
  endtask

  task automatic t_arm;
    enable_i = 1'b1;
    for (int i = 0; i < 3; i++) tick(1'b0, "R2");
    rdy_i = 1'b1;
    tick(1'b0, "R2");
    tick(1'b1, "R2");
  endtask

  task automatic t_full;
    cal_len_i = '0;
    for (int i = 0; i < 8; i++) tick(1'b1, "R3 R6 R7");
  endtask

  task automatic t_halved;
    rdy_i = 1'b0;
    for (int i = 0; i < 6; i++) tick(logic'(i % 2), "R4");
    rdy_i = 1'b1;
    for (int i = 0; i < 3; i++) tick(1'b1, "R5");
  endtask

  task automatic t_enable;
    enable_i = 1'b0;
    for (int i = 0; i < 3; i++) tick(1'b0, "R8");
    rdy_i = 1'b0;
    tick(1'b0, "R8");
    tick(1'b0, "R8");
    rdy_i = 1'b1;
    enable_i = 1'b1;
    tick(1'b1, "R8");
    tick(1'b1, "R8");
  endtask

  task automatic t_cal_write;
    enable_i = 1'b0;
    wr_en_i = 1'b1;
    wr_addr_i = PW'(2); wr_ch_i = CW'(17); wr_sic_i = 6'd45;
    tick(1'b0, "R9");
    wr_addr_i = PW'(0); wr_ch_i = CW'(9);  wr_sic_i = 6'd0;
    tick(1'b0, "R9");
    wr_addr_i = PW'(1); wr_ch_i = CW'(30); wr_sic_i = 6'd63;
    tick(1'b0, "R9");
    wr_addr_i = m_ptr[PW-1:0]; wr_ch_i = CW'(21); wr_sic_i = 6'd7;
    tick(1'b0, "R9");
    wr_en_i = 1'b0;
    tick(1'b0, "R9");
    cal_len_i = LW'(3);
    enable_i = 1'b1;
    for (int i = 0; i < 7; i++) tick(1'b1, "R6 R7 R9");
  endtask

  task automatic t_len;
    cal_len_i = LW'(7);
    for (int i = 0; i < 8; i++) tick(1'b1, "R7");
    cal_len_i = LW'(1);
    for (int i = 0; i < 4; i++) tick(1'b1, "R7");
    rdy_i = 1'b0;
    for (int i = 0; i < 4; i++) tick(logic'(i % 2), "R4");
    rdy_i = 1'b1;
    tick(1'b1, "R5");
  endtask

  initial begin
    @(posedge clk_i);
    #1;
    t_reset();
    t_arm();
    t_full();
    t_halved();
    t_enable();
    t_cal_write();
    t_len();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule